// File: doc/BRIEF.md
# Chunked Vector Sum Reducer

This block turns a stream of integer elements into one scalar sum. Elements arrive as chunks as wide as an internal vector of partial sums. Each accepted chunk is added lane by lane into that vector. When the chunk flagged as last has been taken, the block folds the vector: on each pass the upper half of the still-active entries is added into the lower half, and the active length halves. After log2 of the lane count passes, lane zero holds the total, which is presented on a held valid/ready result port.

A stream may start with a short chunk, which covers the remainder of the element count modulo the lane count; every chunk after it is full. The short chunk's length is given with the chunk, and lanes beyond it count as zero. While folding and while the result waits to be taken, no new chunk is accepted. Taking the result clears the partial sums for the next stream.

Top module: `vec_sum_reducer`

## Requirements
- R1: After reset `inReady` is 1, `resValid` is 0 and `donePulse` is 0.
- R2: Every chunk accepted (`inValid` and `inReady` both high at a rising edge) is added lane by lane into the partial sums; lane i occupies bits [i*LANE_W +: LANE_W] of `inData`, and the result equals the sum of all contributing lanes of the stream.
- R3: On the first chunk of a stream, lanes with index at or above `inLen` contribute zero; `inLen` equal to 0 means the full chunk.
- R4: On any chunk after the first of a stream, `inLen` has no effect and all lanes contribute.
- R5: When the last chunk (`inLast` high) is accepted at edge k, `resValid` goes high after edge k+log2(LANES) and not earlier.
- R6: `inReady` is low from the edge that accepts the last chunk until the edge at which the result is taken (`resValid` and `resReady` high).
- R7: `donePulse` is high for exactly the first cycle in which `resValid` is high.
- R8: While `resValid` is high and `resReady` low, `resValid` and `resData` stay unchanged.
- R9: Taking the result clears all partial sums, so the next stream's result depends on its own elements only.
- R10: Additions wrap modulo 2^LANE_W.
- R11: A stream of one chunk, flagged both first and last, gives its own (masked) sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Chunk offered |
| inReady | output | 1 | Chunk can be accepted |
| inData | input | LANES*LANE_W | Chunk, lane i in bits [i*LANE_W +: LANE_W] |
| inLen | input | log2(LANES)+1 | Active lanes of a stream's first chunk, 0 = all |
| inLast | input | 1 | Chunk ends the stream |
| resValid | output | 1 | Result present |
| resReady | input | 1 | Result taken when high with resValid |
| resData | output | LANE_W | Reduced sum |
| donePulse | output | 1 | One-cycle mark of a new result |

## Verification
The bench aims at the short first chunk, including length one and the zero code for full, where a design that masked wrongly would add stray lanes or drop real ones; it also puts a short length on later chunks, which a design that masked every chunk would drop. It counts the cycles from the last chunk to the result, catching a fold that takes one pass too many or too few, and holds the result back for random spans to catch a value that drifts or a repeated done pulse. Back-to-back streams expose partial sums left over from the previous stream, and all-ones lanes check the wrap.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int STEP_BITS = 6;

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_FOLD   = 2'd1,
    ST_OFFER  = 2'd2
  } vsrState_t;

  typedef struct packed {
    logic                 clear;
    logic                 accum;
    logic                 maskFirst;
    logic                 fold;
    logic [STEP_BITS-1:0] step;
  } vsrCtl_t;
endpackage

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    resReady,
  output logic    inReady,
  output logic    resValid,
  output logic    donePulse,
  output vsrCtl_t ctl
);
  localparam int PASSES = $clog2(LANES);
  localparam logic [STEP_BITS-1:0] LAST_STEP = STEP_BITS'(PASSES - 1);

  vsrState_t state;
  logic firstChunk;
  logic [STEP_BITS-1:0] foldStep;
  logic doneQ;

  assign inReady   = (state == ST_GATHER);
  assign resValid  = (state == ST_OFFER);
  assign donePulse = doneQ;

  always_comb begin
    ctl.accum     = inReady && inValid;
    ctl.maskFirst = firstChunk;
    ctl.fold      = (state == ST_FOLD);
    ctl.step      = foldStep;
    ctl.clear     = resValid && resReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_GATHER;
      firstChunk <= 1'b1;
      foldStep   <= '0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_GATHER: if (inValid) begin
          firstChunk <= 1'b0;
          if (inLast) begin
            state    <= ST_FOLD;
            foldStep <= '0;
          end
        end
        ST_FOLD: begin
          if (foldStep == LAST_STEP) begin
            state <= ST_OFFER;
            doneQ <= 1'b1;
          end else begin
            foldStep <= foldStep + 1'b1;
          end
        end
        ST_OFFER: if (resReady) begin
          state      <= ST_GATHER;
          firstChunk <= 1'b1;
        end
        default: state <= ST_GATHER;
      endcase
    end
  end

  // R6: the last chunk closes the input port
  a_r6_close_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);
  // R5: the final fold pass yields the result
  a_r5_fold_ends: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fold && ctl.step == LAST_STEP) |=> resValid);
  // R7: done marks the first result cycle only
  a_r7_done_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> donePulse);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R8: result stays offered until taken
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> resValid);
endmodule

// File: rtl/vsr_datapath.sv
module vsr_datapath
  import vsr_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  vsrCtl_t                   ctl,
  input  logic [LANES*LANE_W-1:0]   inData,
  input  logic [$clog2(LANES):0]    inLen,
  output logic [LANE_W-1:0]         sumOut
);
  localparam int PASSES = $clog2(LANES);
  localparam int LEN_W  = PASSES + 1;

  logic [LANE_W-1:0] part     [LANES];
  logic [LANE_W-1:0] addend   [LANES];
  logic [LANE_W-1:0] foldNext [LANES];
  logic [LANE_W-1:0] foldCand [LANES][PASSES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic laneOn;
    assign laneOn    = !ctl.maskFirst || (inLen == '0) || (LEN_W'(i) < inLen);
    assign addend[i] = laneOn ? inData[i*LANE_W +: LANE_W] : '0;

    for (genvar s = 0; s < PASSES; s++) begin : g_pass
      if (i < (LANES >> (s + 1))) begin : g_fold
        assign foldCand[i][s] = part[i] + part[i + (LANES >> (s + 1))];
      end else begin : g_keep
        assign foldCand[i][s] = part[i];
      end
    end

    always_comb begin
      foldNext[i] = part[i];
      for (int s = 0; s < PASSES; s++) begin
        if (ctl.step == STEP_BITS'(s)) foldNext[i] = foldCand[i][s];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || ctl.clear) part[i] <= '0;
      else if (ctl.accum)     part[i] <= part[i] + addend[i];
      else if (ctl.fold)      part[i] <= foldNext[i];
    end
  end

  assign sumOut = part[0];

  // R9: taking the result empties the partial sums
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (part[0] == '0 && part[LANES-1] == '0));
  // R8: without a strobe from control the sum does not move
  a_r8_sum_steady: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.clear || ctl.accum || ctl.fold) |=> $stable(sumOut));
  // R2: strobes from control never overlap
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.clear, ctl.accum, ctl.fold}));
endmodule

// File: rtl/vec_sum_reducer.sv
module vec_sum_reducer
  import vsr_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES*LANE_W-1:0] inData,
  input  logic [$clog2(LANES):0]  inLen,
  input  logic                    inLast,
  output logic                    resValid,
  input  logic                    resReady,
  output logic [LANE_W-1:0]       resData,
  output logic                    donePulse
);
  vsrCtl_t ctl;

  initial begin
    assert (LANES >= 2 && (LANES & (LANES - 1)) == 0 && $clog2(LANES) <= (1 << STEP_BITS))
      else $error("LANES must be a power of two of at least 2");
  end

  vsr_ctrl #(.LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .resReady(resReady), .inReady(inReady), .resValid(resValid),
    .donePulse(donePulse), .ctl(ctl)
  );

  vsr_datapath #(.LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inLen(inLen),
    .sumOut(resData)
  );
endmodule

// File: tb/tb_vec_sum_reducer.sv
module tb_vec_sum_reducer;
  localparam int LANES  = 8;
  localparam int LANE_W = 32;
  localparam int PASSES = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, resReady = 1'b0;
  logic [LANES*LANE_W-1:0] inData = '0;
  logic [3:0] inLen = '0;
  logic inReady, resValid, donePulse;
  logic [LANE_W-1:0] resData;

  int checks = 0, fails = 0;
  logic [LANE_W-1:0] expSum;

  always #2.5 clk = ~clk;

  vec_sum_reducer #(.LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLen(inLen), .inLast(inLast), .resValid(resValid),
    .resReady(resReady), .resData(resData), .donePulse(donePulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LANE_W-1:0] chunkSum(input logic [LANES*LANE_W-1:0] d,
                                                 input int len, input bit first);
    logic [LANE_W-1:0] s = '0;
    for (int i = 0; i < LANES; i++)
      if (!first || len == 0 || i < len) s += d[i*LANE_W +: LANE_W];
    return s;
  endfunction

  // send one chunk; first chunk is masked by len (R3), later ones not (R4)
  task automatic sendChunk(input logic [LANES*LANE_W-1:0] d, input int len,
                           input bit first, input bit last);
    inData = d; inLen = 4'(len); inLast = last; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    expSum += chunkSum(d, len, first);
    if (last) check(!inReady, "R6 ready after last", inReady, 0);
  endtask

  task automatic collect(input int holdCycles, input string tag);
    int cnt = 0;
    while (!resValid && cnt < 20) begin
      check(!donePulse, "R7 early done", donePulse, 0);
      @(negedge clk); cnt++;
    end
    check(cnt == PASSES, "R5 fold latency", cnt, PASSES);
    check(donePulse, "R7 done with first result", donePulse, 1);
    check(resData == expSum, tag, resData, expSum);
    for (int h = 0; h < holdCycles; h++) begin
      @(negedge clk);
      check(resValid && resData == expSum, "R8 held result", resData, expSum);
      check(!donePulse, "R7 single done", donePulse, 0);
      check(!inReady, "R6 busy while offering", inReady, 0);
    end
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check(!resValid && inReady, "R9 result taken, ready again", {resValid, inReady}, 2'b01);
    expSum = '0;
  endtask

  function automatic logic [LANES*LANE_W-1:0] randChunk(input bit big);
    logic [LANES*LANE_W-1:0] d;
    for (int i = 0; i < LANES; i++)
      d[i*LANE_W +: LANE_W] = big ? ($urandom | 32'hF000_0000) : LANE_W'($urandom_range(0, 1000));
    return d;
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R5 watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [LANES*LANE_W-1:0] d;
    void'($urandom(32'd4242));
    expSum = '0;
    repeat (3) @(negedge clk);
    check(inReady && !resValid && !donePulse, "R1 reset state",
          {inReady, resValid, donePulse}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady && !resValid && !donePulse, "R1 after release",
          {inReady, resValid, donePulse}, 3'b100);

    // R11: single full chunk, lanes 1..8
    for (int i = 0; i < LANES; i++) d[i*LANE_W +: LANE_W] = LANE_W'(i + 1);
    sendChunk(d, 0, 1, 1);
    collect(0, "R11 single chunk sum");
    check(expSum == 0, "R9 model cleared", expSum, 0);

    // R3: first chunk length 1, then a full chunk
    sendChunk(d, 1, 1, 0);
    sendChunk(d, 0, 0, 1);
    collect(2, "R3 short first chunk");

    // R4: short length on a later chunk is ignored
    sendChunk(d, 5, 1, 0);
    sendChunk(d, 2, 0, 0);
    sendChunk(d, 1, 0, 1);
    collect(1, "R4 later length ignored");

    // R10: all-ones lanes wrap
    d = '1;
    sendChunk(d, 0, 1, 0);
    sendChunk(d, 0, 0, 1);
    collect(0, "R10 wraparound sum");

    // R3 and R11: single short chunk of 7
    d = randChunk(0);
    sendChunk(d, 7, 1, 1);
    collect(3, "R3 single short chunk");

    // R2 and R9: random streams back to back
    for (int s = 0; s < 40; s++) begin
      int n = $urandom_range(1, 5);
      for (int c = 0; c < n; c++)
        sendChunk(randChunk(s % 3 == 0), (c == 0) ? $urandom_range(0, LANES) : $urandom_range(0, LANES),
                  c == 0, c == n - 1);
      collect($urandom_range(0, 3), "R2 random stream sum");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule